// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs single read or write transactions against an Ethernet PHY over a two-wire serial management link. The link consists of a management clock, a data-out line with a separate output-enable, and a data-in line. A requester presents a register number and, for a write, a 16-bit value. The block then emits one complete frame at a management clock rate derived from the system clock by a fixed divider.

Each frame opens with 33 clocks of all-ones preamble. A start pair, an opcode pair, an all-zero PHY address and the register number follow, each sent most significant bit first. A write continues with a driven turnaround pair and the 16-bit value. A read releases the data line, spends one clock in turnaround and then shifts in 16 bits from the PHY. A one-cycle done strobe closes every frame. A busy flag covers the whole transaction, and requests that arrive during it are dropped.

Top module: `mgmt_frame_master`

## Requirements
- R1: While reset is held and after its release with no request, mgmtClk, mgmtOe, busy and done are all 0.
- R2: Every frame starts with 33 management clock rising edges at which mgmtOut is 1 and mgmtOe is 1.
- R3: After the preamble, the next two rising edges carry the start pair 0 then 1. The two after those carry the opcode: 0 then 1 when reqWrite is 1, and 1 then 0 when reqWrite is 0.
- R4: The opcode is followed by five rising edges carrying 0 (PHY address zero), then five carrying reqReg from bit 4 down to bit 0.
- R5: A write frame has exactly 65 rising edges, all with mgmtOe at 1. Rising edges 48 and 49 (counting from 1) carry 1 then 0, and rising edges 50 to 65 carry reqWdata from bit 15 down to bit 0.
- R6: A read frame has exactly 64 rising edges. mgmtOe is 1 at the first 47 and 0 at the remaining 17. rdData at done holds the mgmtIn values seen during rising edges 49 to 64, the first of them in bit 15. mgmtIn is sampled in the last system cycle of each clock-high phase.
- R7: mgmtOut never changes while mgmtClk is high, including the cycle in which mgmtClk rises.
- R8: Each high phase and each low phase of mgmtClk within a frame lasts HALF_DIV system clocks, giving a period of 2*HALF_DIV (HALF_DIV at least 2).
- R9: busy is 1 from the cycle after a request is accepted while idle until done. done is a single-cycle pulse, seen slots*2*HALF_DIV clock edges after the accepting edge (slots is 65 for a write and 64 for a read), with busy already 0.
- R10: A request presented while busy is ignored. The frame in progress is unchanged, and no further frame or done follows it.
- R11: When a frame ends, mgmtClk is 0 and mgmtOe is 0, so the data line is released; both stay there until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqWrite | input | 1 | 1 selects a write frame, 0 a read frame |
| reqReg | input | 5 | PHY register number |
| reqWdata | input | 16 | Value for a write frame |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| rdData | output | 16 | Value collected by the last read frame |
| mgmtClk | output | 1 | Management clock |
| mgmtOut | output | 1 | Management data toward the PHY |
| mgmtOe | output | 1 | Drive enable for mgmtOut; 0 means high impedance |
| mgmtIn | input | 1 | Management data from the PHY |

## Verification
busy is due in the cycle after the accepting edge. done, with its final rdData, is due exactly slots*2*HALF_DIV edges after that edge. The bench counts edges from acceptance and samples on the falling system clock edge, so it checks done in that exact cycle and checks that it is gone one cycle later. Per-bit frame contents are recorded at each management clock rising edge. The responder changes mgmtIn on management clock falling edges, so a value is always settled well before the end of the high phase in which the block samples it.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2
  } mfm_state_t;

  // strobes from sequencing control to the shift datapath
  typedef struct packed {
    logic load;    // capture a new request into the frame shifter
    logic shift;   // move to the next outgoing bit (at falling edge)
    logic sample;  // capture mgmtIn into the read shifter
  } mfm_strobe_t;

endpackage

// File: rtl/mfm_ctrl.sv
module mfm_ctrl
  import mfm_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int PRE_LEN   = 33,
  parameter int ADDR_W    = 5,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output mfm_strobe_t strb,
  output logic        busy,
  output logic        done,
  output logic        mgmtClk,
  output logic        mgmtOe
);
  // slots driven by the master before any read turnaround
  localparam int DRV_SLOTS = PRE_LEN + 2 + 2 + ADDR_W + REG_W;
  localparam int WR_SLOTS  = DRV_SLOTS + 2 + DATA_W;
  localparam int RD_SLOTS  = DRV_SLOTS + 1 + DATA_W;
  localparam int SW        = $clog2(WR_SLOTS + 1);
  localparam int CW        = $clog2(HALF_DIV + 1);

  mfm_state_t    state;
  logic [CW-1:0] cnt;
  logic [SW-1:0] slot;
  logic          isRead;
  logic          accept;
  logic          halfEnd;
  logic          lastSlot;
  logic          frameEnd;

  always_comb begin
    accept      = (state == S_IDLE) && reqValid;
    halfEnd     = (cnt == CW'(HALF_DIV - 1));
    lastSlot    = isRead ? (slot == SW'(RD_SLOTS - 1)) : (slot == SW'(WR_SLOTS - 1));
    frameEnd    = (state == S_HIGH) && halfEnd && lastSlot;
    strb.load   = accept;
    strb.shift  = (state == S_HIGH) && halfEnd && !lastSlot;
    strb.sample = (state == S_HIGH) && halfEnd && isRead && (slot >= SW'(DRV_SLOTS + 1));
    busy        = (state != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      slot    <= '0;
      isRead  <= 1'b0;
      mgmtClk <= 1'b0;
      mgmtOe  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= frameEnd;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            state   <= S_LOW;
            cnt     <= '0;
            slot    <= '0;
            isRead  <= !reqWrite;
            mgmtOe  <= 1'b1;
            mgmtClk <= 1'b0;
          end
        end
        S_LOW: begin
          if (halfEnd) begin
            state   <= S_HIGH;
            mgmtClk <= 1'b1;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (halfEnd) begin
            cnt     <= '0;
            mgmtClk <= 1'b0;
            if (lastSlot) begin
              state  <= S_IDLE;
              mgmtOe <= 1'b0;
            end else begin
              state <= S_LOW;
              slot  <= slot + 1'b1;
              // release the line once the register field has gone out
              if (isRead && slot == SW'(DRV_SLOTS - 1)) mgmtOe <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: busy already dropped when done shows
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R11: lines parked at frame end
  a_r11_parked: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!mgmtClk && !mgmtOe));
  // R8: a high phase lasts more than one cycle
  a_r8_high_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mgmtClk) |=> mgmtClk);
  // R10: a request during a frame does not alter the frame type
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> $stable(isRead));

endmodule

// File: rtl/mfm_datapath.sv
module mfm_datapath
  import mfm_pkg::*;
#(
  parameter int PRE_LEN = 33,
  parameter int ADDR_W  = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mfm_strobe_t       strb,
  input  logic              reqWrite,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              mgmtIn,
  output logic              mgmtOut,
  output logic [DATA_W-1:0] rdData
);
  localparam int TX_W = PRE_LEN + 2 + 2 + ADDR_W + REG_W + 2 + DATA_W;

  logic [TX_W-1:0] txShift;
  logic [TX_W-1:0] txImage;
  logic [1:0]      opBits;

  always_comb begin
    opBits  = reqWrite ? 2'b01 : 2'b10;
    txImage = {{PRE_LEN{1'b1}}, 2'b01, opBits, {ADDR_W{1'b0}}, reqReg, 2'b10, reqWdata};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rdData  <= '0;
    end else begin
      if (strb.load) begin
        txShift <= txImage;
        rdData  <= '0;
      end else begin
        if (strb.shift)  txShift <= {txShift[TX_W-2:0], 1'b0};
        if (strb.sample) rdData  <= {rdData[DATA_W-2:0], mgmtIn};
      end
    end
  end

  assign mgmtOut = txShift[TX_W-1];

  // R2: a freshly loaded frame starts with a preamble one
  a_r2_load_one: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> mgmtOut);

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mfm_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 33,
  parameter int ADDR_W   = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              mgmtClk,
  output logic              mgmtOut,
  output logic              mgmtOe,
  input  logic              mgmtIn
);
  mfm_strobe_t strb;

  mfm_ctrl #(
    .HALF_DIV(HALF_DIV), .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W),
    .REG_W(REG_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .strb(strb), .busy(busy), .done(done), .mgmtClk(mgmtClk), .mgmtOe(mgmtOe)
  );

  mfm_datapath #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite), .reqReg(reqReg),
    .reqWdata(reqWdata), .mgmtIn(mgmtIn), .mgmtOut(mgmtOut), .rdData(rdData)
  );

  // R7: data held while the management clock is high
  a_r7_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    mgmtClk |-> $stable(mgmtOut));
  // R6: sampling only happens with the line released
  a_r6_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> (!mgmtOe && mgmtClk));

endmodule

// File: tb/tb_mgmt_frame_master.sv
module tb_mgmt_frame_master;
  localparam int H      = 2;
  localparam int DRV    = 47;
  localparam int WR_N   = 65;
  localparam int RD_N   = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [4:0]  reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done, mgmtClk, mgmtOut, mgmtOe;
  logic [15:0] rdData;
  logic        mgmtIn = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int riseCnt = 0;
  int doneCnt = 0;
  int highRun = 0;
  int periodErr = 0;
  int stabErr = 0;
  logic prevClk = 1'b0;
  logic prevOut = 1'b0;
  logic [15:0] resp = '0;
  logic capBit [0:79];
  logic capOe  [0:79];

  always #2.5 clk = ~clk;  // 200 MHz

  mgmt_frame_master #(.HALF_DIV(H)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReg(reqReg), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdData(rdData), .mgmtClk(mgmtClk), .mgmtOut(mgmtOut), .mgmtOe(mgmtOe),
    .mgmtIn(mgmtIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY-side recording at each management rising edge
  always @(posedge mgmtClk) begin
    if (riseCnt < 80) begin
      capBit[riseCnt] = mgmtOut;
      capOe[riseCnt]  = mgmtOe;
    end
    riseCnt = riseCnt + 1;
  end

  // responder: present read data after each falling edge in the data window
  always @(negedge mgmtClk) begin
    if (riseCnt >= DRV + 1 && riseCnt < RD_N) mgmtIn = resp[15 - (riseCnt - DRV - 1)];
  end

  // phase length and stability monitors, watchdog
  always @(negedge clk) begin
    cycles++;
    if (done) doneCnt++;
    if (mgmtClk) highRun++;
    else if (prevClk) begin
      if (highRun != H) periodErr++;
      highRun = 0;
    end
    if (mgmtClk && mgmtOut !== prevOut) stabErr++;
    prevClk = mgmtClk;
    prevOut = mgmtOut;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic expBit(input bit wr, input logic [4:0] rg,
                                  input logic [15:0] wd, input int i);
    if (i < 33) return 1'b1;
    if (i == 33) return 1'b0;
    if (i == 34) return 1'b1;
    if (i == 35) return wr ? 1'b0 : 1'b1;
    if (i == 36) return wr ? 1'b1 : 1'b0;
    if (i < 42) return 1'b0;
    if (i < 47) return rg[46 - i];
    if (i == 47) return 1'b1;
    if (i == 48) return 1'b0;
    return wd[64 - i];
  endfunction

  task automatic frame(input bit wr, input logic [4:0] rg, input logic [15:0] wd,
                       input logic [15:0] rsp, input bit inject);
    int n, k, badPre, badHdr, badReg, badTail, badOe;
    n = wr ? WR_N : RD_N;
    resp = rsp;
    @(negedge clk);
    riseCnt = 0; doneCnt = 0; periodErr = 0; stabErr = 0;
    reqValid = 1'b1; reqWrite = wr; reqReg = rg; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    k = 0;
    while (k < 2000) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (inject && k == 40) begin
        reqValid = 1'b1; reqWrite = !wr; reqReg = ~rg; reqWdata = ~wd;
      end
      if (inject && k == 42) reqValid = 1'b0;
      if (done) break;
    end
    check(k == n * 2 * H, "R9 done latency", k, n * 2 * H);
    check(done && !busy, "R9 done without busy", {done, busy}, 2);
    check(!mgmtClk && !mgmtOe, "R11 lines parked at done", {mgmtClk, mgmtOe}, 0);
    if (!wr) check(rdData == rsp, "R6 read data", rdData, rsp);
    check(riseCnt == n, wr ? "R5 write clock count" : "R6 read clock count", riseCnt, n);
    badPre = 0; badHdr = 0; badReg = 0; badTail = 0; badOe = 0;
    for (int i = 0; i < n && i < 80; i++) begin
      logic eb;
      eb = expBit(wr, rg, wd, i);
      if (i < 33) begin
        if (capBit[i] !== 1'b1 || capOe[i] !== 1'b1) badPre++;
      end else if (i < 37) begin
        if (capBit[i] !== eb) badHdr++;
      end else if (i < 47) begin
        if (capBit[i] !== eb) badReg++;
      end else if (wr && capBit[i] !== eb) badTail++;
      if (capOe[i] !== ((wr || i < DRV) ? 1'b1 : 1'b0)) badOe++;
    end
    check(badPre == 0, "R2 preamble", badPre, 0);
    check(badHdr == 0, "R3 start and opcode", badHdr, 0);
    check(badReg == 0, "R4 address and register", badReg, 0);
    if (wr) check(badTail == 0, "R5 turnaround and data", badTail, 0);
    check(badOe == 0, wr ? "R5 enable held" : "R6 enable released", badOe, 0);
    check(periodErr == 0, "R8 high phase length", periodErr, 0);
    check(stabErr == 0, "R7 out stable while high", stabErr, 0);
    @(negedge clk);
    check(!done, "R9 done single pulse", done, 0);
    repeat (12) @(negedge clk);
    check(!busy && !mgmtClk && !mgmtOe, "R11 idle after frame", {busy, mgmtClk, mgmtOe}, 0);
    if (inject) begin
      check(doneCnt == 1 && riseCnt == n, "R10 busy request ignored", riseCnt, n);
    end
  endtask

  initial begin
    process::self().srandom(32'h1d5e);
    repeat (5) begin
      @(negedge clk);
      check(!mgmtClk && !mgmtOe && !busy && !done, "R1 reset state",
            {mgmtClk, mgmtOe, busy, done}, 0);
    end
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!mgmtClk && !mgmtOe && !busy && !done, "R1 idle after reset",
          {mgmtClk, mgmtOe, busy, done}, 0);
    // directed corners
    frame(1'b1, 5'd0,  16'h0000, 16'h0, 1'b0);
    frame(1'b1, 5'd31, 16'hFFFF, 16'h0, 1'b0);
    frame(1'b0, 5'd31, 16'h0,    16'hA5A5, 1'b0);
    frame(1'b0, 5'd0,  16'h0,    16'h0000, 1'b0);
    frame(1'b0, 5'd21, 16'h0,    16'hFFFF, 1'b0);
    frame(1'b0, 5'd10, 16'h0,    16'h8001, 1'b1);
    frame(1'b1, 5'd17, 16'h1234, 16'h0,    1'b1);
    // random mix
    for (int t = 0; t < 12; t++) begin
      frame(1'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule